// File: doc/BRIEF.md
# USB Host Port Suspend and Resume Control

This block holds the power-management bits of one downstream port of a USB 2.0 host controller. These are the suspend bit, the forced-resume bit and the over-current change flag. It also runs the sequencing that links them to events on the bus.

A suspend request from software is held back until the current bus transaction finishes. Once the port is suspended, traffic toward the device is blocked. A resume can start in two ways:

- Software writes the resume bit.
- The bus reports a J-to-K transition.

Only the second source raises a one-cycle port-change pulse toward the global status register. When software ends a resume, the resume bit stays set until the bus reaches high-speed idle. A cycle counter flags an error if that idle does not arrive within a parameterized budget, sized for 2 ms.

Software reaches the register through a synchronous byte-wide port at one address. Reads return data one cycle after the request.

Top module: `usb_port_pm_reg`

## Requirements
- R1: After reset, every register bit reads 0, and `block_ds`, `drive_k`, `port_chg` and `resume_tmo` are low.
- R2: A read with `rd_en` high at address `REG_ADDR` returns, one clock later, bit0 = suspend, bit1 = resume, bit2 = over-current change, bit3 = `port_en`, bit4 = registered `oc_active`, bit5 = timeout flag, and bits 7:6 = 0.
- R3: Writing 1 to bit0 while the port is enabled and no transaction is in progress suspends the port at the next clock. `block_ds` is high whenever the port is enabled, suspended and `port_rst` is low.
- R4: Writing 1 to bit0 while `xact_busy` is high leaves bit0 reading 0. The port suspends at the first clock on which `xact_busy` is low.
- R5: Writing 0 to bit0 has no effect on the suspend bit.
- R6: Writing 1 to bit0 while `port_en` is low is ignored, and the suspend bit stays 0.
- R7: A rising edge of `port_rst` clears suspend, any pending suspend and resume. `block_ds` is low while `port_rst` is high.
- R8: `jk_detect` while the port is enabled and suspended sets the resume bit and pulses `port_chg` high for exactly one cycle.
- R9: A software write of 1 to bit1 sets resume only when the port is suspended, and never pulses `port_chg`. `drive_k` is high exactly while the resume bit is 1.
- R10: A write with bit1 = 0 while resume is set keeps resume at 1 until `hs_idle` is seen. On that clock, both resume and suspend clear.
- R11: If `hs_idle` is not seen within `IDLE_LIMIT` cycles after resume exit begins, the timeout flag (bit5, `resume_tmo`) sets. It stays set until software writes 1 to bit5.
- R12: Bit2 sets on any change of `oc_active` and clears when software writes 1 to it. A change in the same cycle as the clearing write leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| port_en | input | 1 | Port enabled, from the port status logic |
| port_rst | input | 1 | Port reset, from the port control logic |
| xact_busy | input | 1 | A bus transaction is in progress on this port |
| jk_detect | input | 1 | J-to-K transition seen on the bus |
| oc_active | input | 1 | Over-current condition present |
| hs_idle | input | 1 | Bus has reached high-speed idle |
| block_ds | output | 1 | Block downstream data |
| drive_k | output | 1 | Drive resume K signaling |
| port_chg | output | 1 | One-cycle port-change pulse |
| resume_tmo | output | 1 | Resume exit exceeded the idle budget |

## Verification
The over-current change flag can receive a hardware set and a software clear in the same cycle. The bench provokes this by toggling `oc_active` on exactly the clock that carries the write of 1 to bit2. It then judges the outcome by reading the flag back as still set; a second, undisturbed clear empties it. Deferred suspend is also exercised with the transaction ending in a later cycle. The suspend bit is observed through reads both before and after that edge.

// File: rtl/usb_port_pm_reg.sv
module usb_port_pm_reg #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h2,
  parameter int IDLE_LIMIT = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic              port_en,
  input  logic              port_rst,
  input  logic              xact_busy,
  input  logic              jk_detect,
  input  logic              oc_active,
  input  logic              hs_idle,
  output logic              block_ds,
  output logic              drive_k,
  output logic              port_chg,
  output logic              resume_tmo
);
  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM    = CNT_W'(IDLE_LIMIT);
  localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(IDLE_LIMIT - 1);

  logic susp, pend, fpr, exiting, occ, oc_q, tmo, rst_q;
  logic [CNT_W-1:0] cnt;

  wire hit_wr    = wr_en && (addr == REG_ADDR);
  wire hit_rd    = rd_en && (addr == REG_ADDR);
  wire rst_rise  = port_rst && !rst_q;
  wire idle_done = exiting && hs_idle;
  wire jk_hit    = port_en && susp && !fpr && jk_detect;
  wire sw_set    = hit_wr && wdata[1] && port_en && susp && !fpr;
  wire sw_clr    = hit_wr && !wdata[1] && fpr && !exiting;
  wire waiting   = exiting && !hs_idle;

  assign block_ds   = port_en && susp && !port_rst;
  assign drive_k    = fpr;
  assign resume_tmo = tmo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      susp <= 1'b0; pend <= 1'b0; fpr <= 1'b0; exiting <= 1'b0;
      occ <= 1'b0; oc_q <= 1'b0; tmo <= 1'b0; rst_q <= 1'b0;
      cnt <= '0; port_chg <= 1'b0; rdata <= '0;
    end else begin
      rst_q    <= port_rst;
      oc_q     <= oc_active;
      port_chg <= jk_hit;

      if (rst_rise) begin
        susp <= 1'b0; pend <= 1'b0;
      end else if (idle_done) begin
        susp <= 1'b0;
      end else if (!port_en) begin
        pend <= 1'b0;
      end else if (pend) begin
        if (!xact_busy) begin susp <= 1'b1; pend <= 1'b0; end
      end else if (hit_wr && wdata[0] && !susp) begin
        if (xact_busy) pend <= 1'b1;
        else           susp <= 1'b1;
      end

      if (waiting && cnt != LIM) cnt <= cnt + 1'b1;

      if (rst_rise || idle_done) begin
        fpr <= 1'b0; exiting <= 1'b0;
      end else if (jk_hit || sw_set) begin
        fpr <= 1'b1;
      end else if (sw_clr) begin
        exiting <= 1'b1; cnt <= '0;
      end

      if (waiting && cnt == LIM_M1)  tmo <= 1'b1;
      else if (hit_wr && wdata[5])   tmo <= 1'b0;

      if (oc_active != oc_q)         occ <= 1'b1;
      else if (hit_wr && wdata[2])   occ <= 1'b0;

      if (hit_rd)     rdata <= {2'b00, tmo, oc_q, port_en, occ, fpr, susp};
      else if (rd_en) rdata <= '0;
    end
  end

  // R6
  susp_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp) |-> $past(port_en));
  // R4
  susp_after_xact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp) |-> !$past(xact_busy));
  // R8
  chg_with_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_chg |-> $rose(drive_k));
  // R9
  resume_from_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fpr) |-> $past(susp));
  // R10
  exit_clears_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fpr) |-> !susp);
  // R11
  tmo_during_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> $past(fpr));
endmodule

// File: tb/test_usb_port_pm_reg.sv
module test_usb_port_pm_reg;
  localparam int LIMIT = 20;
  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 4'h2;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic port_en = 0, port_rst = 0, xact_busy = 0, jk_detect = 0, oc_active = 0, hs_idle = 0;
  logic block_ds, drive_k, port_chg, resume_tmo;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_port_pm_reg #(.ADDR_W(4), .REG_ADDR(4'h2), .IDLE_LIMIT(LIMIT)) i_usb_port_pm_reg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .port_en(port_en), .port_rst(port_rst), .xact_busy(xact_busy),
    .jk_detect(jk_detect), .oc_active(oc_active), .hs_idle(hs_idle), .block_ds(block_ds),
    .drive_k(drive_k), .port_chg(port_chg), .resume_tmo(resume_tmo));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_rst();
    @(negedge clk); port_rst = 1;
    @(negedge clk); port_rst = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(d); chk("R1 reg", d, 8'h00);
    chk("R1 outs", {block_ds, drive_k, port_chg, resume_tmo}, 0);
  endtask

  task automatic t_suspend_now();
    logic [7:0] d;
    port_en = 1; wr(8'h01);
    chk("R3 block", block_ds, 1);
    rd(d); chk("R2 R3 read", d, 8'h09);
  endtask

  task automatic t_write_zero();
    logic [7:0] d;
    wr(8'h00); rd(d); chk("R5 zero ignored", d, 8'h09);
  endtask

  task automatic t_port_reset();
    logic [7:0] d;
    @(negedge clk); port_rst = 1; #1;
    chk("R7 block in reset", block_ds, 0);
    @(negedge clk); port_rst = 0;
    rd(d); chk("R7 cleared", d, 8'h08);
  endtask

  task automatic t_deferred();
    logic [7:0] d;
    xact_busy = 1; wr(8'h01);
    rd(d); chk("R4 pending", d, 8'h08);
    chk("R4 no block", block_ds, 0);
    @(negedge clk); xact_busy = 0;
    @(negedge clk); chk("R4 block after", block_ds, 1);
    rd(d); chk("R4 read", d, 8'h09);
    pulse_rst();
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    port_en = 0; wr(8'h01);
    rd(d); chk("R6 disabled", d, 8'h00);
    port_en = 1;
    rd(d); chk("R6 enabled back", d, 8'h08);
  endtask

  task automatic t_jk_resume();
    logic [7:0] d;
    wr(8'h01);
    @(negedge clk); jk_detect = 1;
    @(negedge clk); jk_detect = 0;
    chk("R8 chg pulse", port_chg, 1);
    chk("R8 drive_k", drive_k, 1);
    @(negedge clk); chk("R8 chg one cycle", port_chg, 0);
    rd(d); chk("R8 read", d, 8'h0B);
    hs_idle = 0; wr(8'h01);
    cyc(3);
    rd(d); chk("R10 held", d, 8'h0B);
    chk("R10 still K", drive_k, 1);
    @(negedge clk); hs_idle = 1;
    @(negedge clk); hs_idle = 0;
    rd(d); chk("R10 done", d, 8'h08);
    chk("R10 unblocked", {block_ds, drive_k}, 0);
  endtask

  task automatic t_sw_resume();
    logic [7:0] d;
    wr(8'h02);
    rd(d); chk("R9 not suspended", d, 8'h08);
    wr(8'h01);
    @(negedge clk); wr_en = 1; wdata = 8'h03;
    @(negedge clk); wr_en = 0;
    chk("R9 no chg", port_chg, 0);
    chk("R9 drive_k", drive_k, 1);
    @(negedge clk); chk("R9 no chg later", port_chg, 0);
    hs_idle = 1; wr(8'h01);
    rd(d); chk("R10 idle exit", d, 8'h08);
    hs_idle = 0;
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    wr(8'h01); wr(8'h03); wr(8'h01);
    cyc(5); chk("R11 not early", resume_tmo, 0);
    cyc(25); chk("R11 flag", resume_tmo, 1);
    rd(d); chk("R11 read", d, 8'h2B);
    @(negedge clk); hs_idle = 1;
    @(negedge clk); hs_idle = 0;
    rd(d); chk("R11 sticky", d, 8'h28);
    wr(8'h20);
    rd(d); chk("R11 cleared", d, 8'h08);
  endtask

  task automatic t_occ();
    logic [7:0] d;
    @(negedge clk); oc_active = 1;
    rd(d); chk("R12 set", d, 8'h1C);
    wr(8'h04);
    rd(d); chk("R12 clear", d, 8'h18);
    @(negedge clk); oc_active = 0;
    rd(d); chk("R12 fall", d, 8'h0C);
    @(negedge clk); wr_en = 1; wdata = 8'h04; oc_active = 1;
    @(negedge clk); wr_en = 0;
    rd(d); chk("R12 set wins", d, 8'h1C);
    wr(8'h04);
    rd(d); chk("R12 clear after", d, 8'h18);
  endtask

  initial begin
    cyc(3); rst_n = 1;
    t_reset();
    t_suspend_now();
    t_write_zero();
    t_port_reset();
    t_deferred();
    t_disabled();
    t_jk_resume();
    t_sw_resume();
    t_timeout();
    t_occ();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule